// File: doc/BRIEF.md
# Programmable Quadrature Encoder Divider

This block takes the two raw phase signals of an incremental rotary encoder and produces a second quadrature pair that moves N times more slowly. Both inputs are sampled on a fast system clock. The block decodes each single-step change of the sampled pair as one count up or one count down, and feeds that count into a counter that wraps over the range 1..N. Each wrap moves a four-phase output state one place forward or back. A full output cycle therefore takes 4×N input steps. Each output line stays high for exactly half of that cycle, for every N, N=1 included.

The output position follows net clockwise-minus-counter-clockwise motion exactly. A shaft that moves back and forth across one output edge makes that edge move back and forth too, so no error builds up over time. Two flag outputs report the direction of the most recent valid step.

The block has no stream data path. Every pin is a plain level signal, so there is no valid/ready handshake and no back-pressure. The encoder cannot be stalled, and each sampled state is used as soon as it is seen.

Top module: `qenc_divider`

## Requirements
- R1: A step on the encoder inputs that is stable before rising edge k is first seen at the outputs and flags just after rising edge k+1, because of two register stages and then the output registers.
- R2: While the sampled pair {A,B} equals the previous sample, the count, the outputs and the flags keep their values.
- R3: With A as the MSB, the clockwise order of {A,B} is 00, 10, 11, 01, 00. Each step forward in this order counts up, and each step backward counts down.
- R4: A change in which both bits flip together (00 and 11, or 10 and 01) is ignored. It leaves the count, the outputs and the flags unchanged.
- R5: The count stays within 1..N. Counting up from N wraps to 1 (overflow), and counting down from 1 wraps to N (underflow). A divisor input of 0 means N=4096. Over 4×N clockwise steps each output changes twice and is high for 2×N steps.
- R6: On overflow the pair (out_a,out_b) moves 10 to 11 to 01 to 00 to 10. On underflow it moves the opposite way. At most one output changes per clock.
- R7: Reset gives out_a=1, out_b=0, both flags 0, a count of 1 and sampled states of 00. After k net clockwise steps from reset, the phase index floor(k/N) mod 4 selects 10, 11, 01 or 00.
- R8: A valid up step sets dir_cw and clears dir_ccw. A valid down step does the reverse. The flags hold until the next valid step and are never both 1.
- R9: Reversals add no error. Stepping back and forth across an output edge toggles that output each time.
- R10: If N is lowered below the current count, the next valid step sets the count to N and causes no overflow or underflow.
- R11: With N=1 every valid step moves the output phase by one place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Raw encoder phase A |
| enc_b | input | 1 | Raw encoder phase B |
| div_n | input | 12 | Divisor N (0 means 4096) |
| out_a | output | 1 | Divided quadrature phase A |
| out_b | output | 1 | Divided quadrature phase B |
| dir_cw | output | 1 | Last valid step was clockwise |
| dir_ccw | output | 1 | Last valid step was counter-clockwise |

## Verification
The divider is driven with long clockwise runs and counter-clockwise runs at N=3. These runs separate a correct phase order and duty from a swapped or mirrored state machine. Back-and-forth stepping across an output edge exposes any drift on reversal. Diagonal double-bit jumps show whether invalid changes are wrongly counted. Runs at N=1, N=0 (4096) and with N lowered mid-count test the wrap boundaries, the zero encoding and the clamp. A single step is timed clock by clock to pin down the latency.

// File: rtl/qdiv_pkg.sv
package qdiv_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

  // Clockwise position of a sampled {A,B} pair: 00->0, 10->1, 11->2, 01->3
  function automatic logic [1:0] ab_to_pos(input logic [1:0] ab);
    return {ab[0], ab[1] ^ ab[0]};
  endfunction
endpackage

// File: rtl/qdiv_sampler.sv
module qdiv_sampler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enc_a,
  input  logic       enc_b,
  output logic [1:0] cur_ab,
  output logic [1:0] prev_ab
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ab  <= 2'b00;
      prev_ab <= 2'b00;
    end else begin
      cur_ab  <= {enc_a, enc_b};
      prev_ab <= cur_ab;
    end
  end
endmodule

// File: rtl/qdiv_step_decode.sv
module qdiv_step_decode
  import qdiv_pkg::*;
(
  input  logic [1:0] cur_ab,
  input  logic [1:0] prev_ab,
  output step_e      step
);
  logic [1:0] delta;

  always_comb begin
    delta = ab_to_pos(cur_ab) - ab_to_pos(prev_ab);
    unique case (delta)
      2'd1:    step = STEP_UP;
      2'd3:    step = STEP_DN;
      default: step = STEP_NONE; // no change or a double-bit jump
    endcase
  end
endmodule

// File: rtl/qdiv_wrap_counter.sv
module qdiv_wrap_counter
  import qdiv_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step,
  input  logic [DIV_W-1:0] div_n,
  output logic [DIV_W:0]   cnt,
  output logic             wrap_up,
  output logic             wrap_dn
);
  localparam int CNT_W = DIV_W + 1;
  localparam logic [CNT_W-1:0] N_MAX = CNT_W'(1) << DIV_W;
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] n_eff;
  logic             over_limit;

  always_comb begin
    n_eff      = (div_n == '0) ? N_MAX : {1'b0, div_n};
    over_limit = (cnt > n_eff);
    wrap_up    = (step == STEP_UP) && !over_limit && (cnt == n_eff);
    wrap_dn    = (step == STEP_DN) && !over_limit && (cnt == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= ONE;
    end else if (step != STEP_NONE) begin
      if (over_limit)   cnt <= n_eff;
      else if (wrap_up) cnt <= ONE;
      else if (wrap_dn) cnt <= n_eff;
      else if (step == STEP_UP) cnt <= cnt + ONE;
      else              cnt <= cnt - ONE;
    end
  end
endmodule

// File: rtl/qdiv_phase_gen.sv
module qdiv_phase_gen
  import qdiv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  step_e step,
  input  logic  wrap_up,
  input  logic  wrap_dn,
  output logic  out_a,
  output logic  out_b,
  output logic  dir_cw,
  output logic  dir_ccw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_a <= 1'b1;
      out_b <= 1'b0;
    end else if (wrap_up) begin
      out_a <= ~out_b;
      out_b <= out_a;
    end else if (wrap_dn) begin
      out_a <= out_b;
      out_b <= ~out_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_cw  <= 1'b0;
      dir_ccw <= 1'b0;
    end else if (step == STEP_UP) begin
      dir_cw  <= 1'b1;
      dir_ccw <= 1'b0;
    end else if (step == STEP_DN) begin
      dir_cw  <= 1'b0;
      dir_ccw <= 1'b1;
    end
  end
endmodule

// File: rtl/qenc_divider.sv
module qenc_divider
  import qdiv_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic [DIV_W-1:0] div_n,
  output logic             out_a,
  output logic             out_b,
  output logic             dir_cw,
  output logic             dir_ccw
);
  logic [1:0]     cur_ab, prev_ab;
  step_e          step;
  logic [DIV_W:0] cnt;
  logic           wrap_up, wrap_dn;
  logic           step_up, step_dn;

  assign step_up = (step == STEP_UP);
  assign step_dn = (step == STEP_DN);

  qdiv_sampler u_sampler (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .cur_ab(cur_ab), .prev_ab(prev_ab)
  );

  qdiv_step_decode u_decode (
    .cur_ab(cur_ab), .prev_ab(prev_ab), .step(step)
  );

  qdiv_wrap_counter #(.DIV_W(DIV_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .step(step), .div_n(div_n),
    .cnt(cnt), .wrap_up(wrap_up), .wrap_dn(wrap_dn)
  );

  qdiv_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .step(step),
    .wrap_up(wrap_up), .wrap_dn(wrap_dn),
    .out_a(out_a), .out_b(out_b), .dir_cw(dir_cw), .dir_ccw(dir_ccw)
  );
endmodule

// File: rtl/qdiv_checker.sv
module qdiv_checker #(
  parameter int DIV_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_up,
  input logic             step_dn,
  input logic             wrap_up,
  input logic             wrap_dn,
  input logic [DIV_W:0]   cnt,
  input logic             out_a,
  input logic             out_b,
  input logic             dir_cw,
  input logic             dir_ccw
);
  localparam logic [DIV_W:0] CNT_TOP = (DIV_W+1)'(1) << DIV_W;

  p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 1) && (cnt <= CNT_TOP));

  // R4: an ignored double-bit jump decodes as no step, so it is covered here too
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_dn) |=> ($stable(out_a) && $stable(out_b) &&
                                $stable(dir_cw) && $stable(dir_ccw) && $stable(cnt)));

  p_one_bit_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({out_a, out_b} ^ {$past(out_a), $past(out_b)}) <= 1);

  p_overflow_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_up |=> (out_a == !$past(out_b)) && (out_b == $past(out_a)));

  p_underflow_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_dn |=> (out_a == $past(out_b)) && (out_b == !$past(out_a)));

  p_flag_cw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |=> dir_cw && !dir_ccw);

  p_flag_ccw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |=> dir_ccw && !dir_cw);

  p_flags_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dir_cw && dir_ccw));
endmodule

bind qenc_divider qdiv_checker #(.DIV_W(DIV_W)) u_qdiv_chk (
  .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
  .wrap_up(wrap_up), .wrap_dn(wrap_dn), .cnt(cnt),
  .out_a(out_a), .out_b(out_b), .dir_cw(dir_cw), .dir_ccw(dir_ccw)
);

// File: tb/test_qenc_divider.sv
`timescale 1ns/1ps
module test_qenc_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0;
  logic [11:0] div_n = 12'd3;
  logic        out_a, out_b, dir_cw, dir_ccw;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  qenc_divider i_qenc_divider (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .div_n(div_n),
    .out_a(out_a), .out_b(out_b), .dir_cw(dir_cw), .dir_ccw(dir_ccw)
  );

  // ---------------- behavioural reference ----------------
  int m_cur, m_prev, m_cnt;
  bit m_a, m_b, m_cw, m_ccw;

  function automatic int pos_of(int ab);
    case (ab)
      0: return 0; 2: return 1; 3: return 2; default: return 3;
    endcase
  endfunction

  always @(posedge clk) begin
    int nv, d;
    bit ta;
    if (!rst_n) begin
      m_cur = 0; m_prev = 0; m_cnt = 1;
      m_a = 1; m_b = 0; m_cw = 0; m_ccw = 0;
    end else begin
      nv = (div_n == 0) ? 4096 : int'(div_n);
      d  = (pos_of(m_cur) - pos_of(m_prev) + 4) % 4;
      if (d == 1 || d == 3) begin
        m_cw = (d == 1); m_ccw = (d == 3);
        if (m_cnt > nv) m_cnt = nv;
        else if (d == 1) begin
          if (m_cnt == nv) begin
            m_cnt = 1; ta = m_a; m_a = !m_b; m_b = ta;
          end else m_cnt++;
        end else begin
          if (m_cnt == 1) begin
            m_cnt = nv; ta = m_a; m_a = m_b; m_b = !ta;
          end else m_cnt--;
        end
      end
      m_prev = m_cur;
      m_cur  = {enc_a, enc_b};
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ({out_a, out_b} !== {m_a, m_b}) begin
        errors++;
        $display("FAIL R6 outputs per-cycle: actual %b%b expected %b%b at %0t",
                 out_a, out_b, m_a, m_b, $time);
      end
      checks++;
      if ({dir_cw, dir_ccw} !== {m_cw, m_ccw}) begin
        errors++;
        $display("FAIL R8 flags per-cycle: actual %b%b expected %b%b at %0t",
                 dir_cw, dir_ccw, m_cw, m_ccw, $time);
      end
    end
  end

  // Output edge counter
  int edges = 0;
  bit la = 1'b1, lb = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_a != la) edges++;
      if (out_b != lb) edges++;
    end
    la = out_a; lb = out_b;
  end

  // ---------------- stimulus helpers ----------------
  int pos = 0;   // clockwise encoder position 0..3
  int net = 0;   // net steps since reset

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int phase_bits(input int k, input int n);
    int q, g;
    q = (k >= 0) ? k / n : -((-k + n - 1) / n);
    g = ((q % 4) + 4) % 4;
    case (g)
      0: return 2; 1: return 3; 2: return 1; default: return 0;
    endcase
  endfunction

  task automatic drive_pos(input int p);
    case (p)
      0: {enc_a, enc_b} = 2'b00; 1: {enc_a, enc_b} = 2'b10;
      2: {enc_a, enc_b} = 2'b11; default: {enc_a, enc_b} = 2'b01;
    endcase
  endtask

  task automatic do_step(input int d);
    pos = (pos + d + 4) % 4;
    net += d;
    drive_pos(pos);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pos = 0; net = 0; drive_pos(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- tests ----------------
  initial begin
    int hi, e0, ph0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 out_a after reset", out_a, 1);
    check("R7 out_b after reset", out_b, 0);
    check("R7 flags after reset", {dir_cw, dir_ccw}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R5 R7: clockwise run at N=3
    div_n = 12'd3; hi = 0; e0 = edges;
    for (int i = 0; i < 12; i++) begin
      do_step(1);
      check("R7 phase cw", {out_a, out_b}, phase_bits(net, 3));
      if (out_a) hi++;
    end
    check("R5 edges per 4N", edges - e0, 4);
    check("R5 duty out_a", hi, 6);
    check("R8 cw flag", {dir_cw, dir_ccw}, 2);

    // R3 R6: counter-clockwise run back and beyond
    hi = 0;
    for (int i = 0; i < 15; i++) begin
      do_step(-1);
      check("R6 phase ccw", {out_a, out_b}, phase_bits(net, 3));
      if (out_b) hi++;
    end
    check("R5 duty out_b ccw", hi >= 6 ? 1 : 0, 1);
    check("R8 ccw flag", {dir_cw, dir_ccw}, 1);

    // R9: back and forth across an output edge
    while (((net % 3) + 3) % 3 != 2) do_step(1);
    ph0 = {out_a, out_b};
    for (int i = 0; i < 6; i++) begin
      do_step(1);
      check("R9 forward across edge", {out_a, out_b}, phase_bits(net, 3));
      do_step(-1);
      check("R9 back across edge", {out_a, out_b}, ph0);
    end

    // R4: double-bit jumps ignored
    ph0 = {out_a, out_b};
    e0 = {dir_cw, dir_ccw};
    for (int i = 0; i < 2; i++) begin
      pos = (pos + 2) % 4;
      drive_pos(pos);
      repeat (4) @(negedge clk);
      check("R4 outputs after jump", {out_a, out_b}, ph0);
      check("R4 flags after jump", {dir_cw, dir_ccw}, e0);
    end
    // back to a count-consistent place: jumps cancel, pos unchanged overall

    // R11: N=1, every step moves the phase
    do_reset();
    div_n = 12'd1;
    for (int i = 0; i < 5; i++) begin
      do_step(1);
      check("R11 N=1 cw", {out_a, out_b}, phase_bits(net, 1));
    end
    for (int i = 0; i < 7; i++) begin
      do_step(-1);
      check("R11 N=1 ccw", {out_a, out_b}, phase_bits(net, 1));
    end

    // R1: latency of one step (N=1 so the step wraps)
    do_reset();
    div_n = 12'd1;
    pos = 1; drive_pos(1);
    @(negedge clk);
    check("R1 no change after first edge", {out_a, out_b}, 2);
    @(negedge clk);
    check("R1 change after second edge", {out_a, out_b}, 3);
    check("R1 flag after second edge", dir_cw, 1);
    repeat (2) @(negedge clk);

    // R10: lower N below the count
    do_reset();
    div_n = 12'd5;
    for (int i = 0; i < 3; i++) do_step(1);   // count 4
    div_n = 12'd2;
    do_step(1);                                // clamp to 2, no wrap
    check("R10 no wrap on clamp", {out_a, out_b}, 2);
    do_step(1);                                // 2 -> wrap
    check("R10 wrap after clamp", {out_a, out_b}, 3);

    // R5: divisor 0 means 4096
    do_reset();
    div_n = 12'd0;
    for (int i = 0; i < 4095; i++) do_step(1);
    check("R5 N=0 before wrap", {out_a, out_b}, 2);
    do_step(1);
    check("R5 N=0 wrap at 4096", {out_a, out_b}, 3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule